// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback) keeps its results correct while instructions overlap. It looks at the register numbers carried by the decode, execute, memory and writeback stage registers and at their write enables. From these it chooses where each of the two execute-stage operands comes from. It also holds decode for one cycle when a load result is needed too early. On each conditional branch it keeps fetch waiting while the new program counter is computed.

Results produced by the ALU are routed straight into a following instruction's execute stage, without waiting for the register file. A value needed by the instruction right behind a load cannot arrive in time, so that instruction waits one cycle in decode while a no-op moves on. It then picks the loaded value up from writeback. The register file is assumed to write early in a cycle and read late, so a producer three or more instructions ahead needs no help. The block keeps its own record of which of the execute, memory and writeback slots hold a real instruction. Slots it has filled with a no-op, and slots emptied by reset, never act as forwarding sources.

Top module: `hazard_ctl`

## Requirements
- R1: Operand selects use 00 for the register file, 01 for the memory-stage result and 10 for the writeback-stage result, one select per operand. A live memory-stage write whose enable is high and whose destination equals an execute source gives 01 for that operand.
- R2: When the memory stage does not match but a live writeback-stage write with its enable high matches an execute source, that operand's select is 10.
- R3: When both the memory and writeback stages match the same source, the memory stage (the younger result) wins and the select is 01.
- R4: Register 0 never causes forwarding and never causes a load-use stall.
- R5: A valid decode instruction that reads, through either source, the destination of a live load in execute raises stall and bubble for exactly one cycle. Stall is never high in two consecutive cycles. An empty decode slot, a non-matching source or a non-load producer causes no stall.
- R6: Only live slots act as forwarding sources. After a load-use interlock, the consumer in execute gets select 10 while the bubble occupies the memory stage. An empty execute slot gives select 00.
- R7: A valid branch in decode that is not stalled raises redirect_wait_o in that cycle and in the next one (two cycles for the default of two bubbles), then drops it.
- R8: When a branch in decode is itself held by a load-use stall, redirect_wait_o stays low during the stall cycle. Its two-cycle window starts in the following cycle.
- R9: Reset empties all slot records, so in the first cycle after reset no stall and no forward occur whatever the inputs show.
- R10: A producer that is not a load, sitting in execute, never stalls the decode instruction. A decode source matching only the writeback destination needs neither a stall nor forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid_i | input | 1 | Decode register holds a real instruction |
| id_rs1_i | input | 5 | First source register of the decode instruction |
| id_rs2_i | input | 5 | Second source register of the decode instruction |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| ex_rs1_i | input | 5 | First source register of the execute instruction |
| ex_rs2_i | input | 5 | Second source register of the execute instruction |
| ex_rd_i | input | 5 | Destination register of the execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | 5 | Destination register in the memory stage |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Destination register in the writeback stage |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_o | output | 2 | Source select for the first execute operand |
| fwd_b_o | output | 2 | Source select for the second execute operand |
| stall_o | output | 1 | Hold the program counter and the decode register |
| bubble_o | output | 1 | Load a no-op into the execute stage |
| redirect_wait_o | output | 1 | Hold the program counter and load a no-op into decode while a branch resolves |

## Verification
The hardest case to reach from the ports is forwarding right after an interlock. The memory-stage port can still show a matching destination with its enable high, yet the slot holds the no-op that the block inserted itself, and only the block's private slot record says so. The stimulus provokes a real load-use stall, then presents the consumer in execute with stale matching values left on the memory port. It expects the writeback select, which shows that the empty slot was skipped. A second sequence holds a branch in decode behind a load-use stall, to check that the branch window is delayed by one cycle and is not lost.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned NUM_REGS = 32;
    localparam int unsigned RIDX_W   = $clog2(NUM_REGS);

    typedef logic [RIDX_W-1:0] ridx_t;

    // operand source select, one per execute operand
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    // a pending register write held by one pipeline slot
    typedef struct packed {
        logic  live;
        logic  wen;
        ridx_t rd;
    } wr_port_t;

    // true when the slot will write register src (register 0 excluded)
    function automatic logic wr_hits(wr_port_t w, ridx_t src);
        return w.live && w.wen && (w.rd != '0) && (w.rd == src);
    endfunction

endpackage

// File: rtl/hzd_slot_track.sv
module hzd_slot_track #(
    parameter int unsigned N_SLOT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_i,
    output logic [N_SLOT-1:0] live_o
);

    logic [N_SLOT-1:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q[0] <= 1'b0;
        else     live_q[0] <= enter_i;
    end

    generate
        for (genvar s = 1; s < N_SLOT; s++) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) live_q[s] <= 1'b0;
                else     live_q[s] <= live_q[s-1];
            end
        end
    endgenerate

    assign live_o = live_q;

    // R9: every slot record is empty in the first cycle after reset
    p_reset_empty_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_q == '0));

endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
    import hzd_pkg::*;
(
    input  logic     ex_live_i,
    input  ridx_t    src_i,
    input  wr_port_t mem_wr_i,
    input  wr_port_t wb_wr_i,
    output fwd_sel_e sel_o
);

    // the younger (memory-stage) result is checked first
    always_comb begin
        sel_o = FWD_RF;
        if (ex_live_i) begin
            if (wr_hits(mem_wr_i, src_i))     sel_o = FWD_MEM;
            else if (wr_hits(wb_wr_i, src_i)) sel_o = FWD_WB;
        end
    end

endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
    import hzd_pkg::*;
#(
    parameter int unsigned BR_BUBBLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     id_valid_i,
    input  ridx_t    id_rs1_i,
    input  ridx_t    id_rs2_i,
    input  logic     id_branch_i,
    input  wr_port_t ex_wr_i,
    input  logic     ex_load_i,
    output logic     ld_stall_o,
    output logic     redirect_o
);

    localparam int unsigned CW = $clog2(BR_BUBBLES + 1);

    logic [CW-1:0] wait_cnt;
    logic          br_go;

    assign ld_stall_o = id_valid_i && ex_load_i &&
                        (wr_hits(ex_wr_i, id_rs1_i) || wr_hits(ex_wr_i, id_rs2_i));

    // a branch opens its window only once it is free to leave decode
    assign br_go      = id_valid_i && id_branch_i && !ld_stall_o && (wait_cnt == '0);
    assign redirect_o = br_go || (wait_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)                  wait_cnt <= '0;
        else if (br_go)           wait_cnt <= CW'(BR_BUBBLES - 1);
        else if (wait_cnt != '0)  wait_cnt <= wait_cnt - 1'b1;
    end

    // R7: the remaining-window counter never exceeds its range
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        wait_cnt < CW'(BR_BUBBLES));

    // R8: a branch held by a load-use stall opens its window next cycle
    p_branch_after_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (id_valid_i && id_branch_i && ld_stall_o) |=> redirect_o);

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hzd_pkg::*;
#(
    parameter int unsigned BR_BUBBLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid_i,
    input  logic [RIDX_W-1:0] id_rs1_i,
    input  logic [RIDX_W-1:0] id_rs2_i,
    input  logic              id_branch_i,
    input  logic [RIDX_W-1:0] ex_rs1_i,
    input  logic [RIDX_W-1:0] ex_rs2_i,
    input  logic [RIDX_W-1:0] ex_rd_i,
    input  logic              ex_wen_i,
    input  logic              ex_load_i,
    input  logic [RIDX_W-1:0] mem_rd_i,
    input  logic              mem_wen_i,
    input  logic [RIDX_W-1:0] wb_rd_i,
    input  logic              wb_wen_i,
    output logic [1:0]        fwd_a_o,
    output logic [1:0]        fwd_b_o,
    output logic              stall_o,
    output logic              bubble_o,
    output logic              redirect_wait_o
);

    localparam int unsigned N_OPND = 2;
    localparam int unsigned N_SLOT = 3;   // execute, memory, writeback
    localparam int unsigned S_EX   = 0;
    localparam int unsigned S_MEM  = 1;
    localparam int unsigned S_WB   = 2;

    logic [N_SLOT-1:0] slot_live;
    logic              ld_stall;
    logic              redirect;
    wr_port_t          ex_wr, mem_wr, wb_wr;
    ridx_t             ex_src [N_OPND];
    fwd_sel_e          sel    [N_OPND];

    assign ex_wr  = '{live: slot_live[S_EX],  wen: ex_wen_i,  rd: ex_rd_i};
    assign mem_wr = '{live: slot_live[S_MEM], wen: mem_wen_i, rd: mem_rd_i};
    assign wb_wr  = '{live: slot_live[S_WB],  wen: wb_wen_i,  rd: wb_rd_i};

    assign ex_src[0] = ex_rs1_i;
    assign ex_src[1] = ex_rs2_i;

    hzd_slot_track #(.N_SLOT(N_SLOT)) u_track (
        .clk     (clk),
        .rst     (rst),
        .enter_i (id_valid_i && !ld_stall),
        .live_o  (slot_live)
    );

    hzd_interlock #(.BR_BUBBLES(BR_BUBBLES)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .id_valid_i  (id_valid_i),
        .id_rs1_i    (id_rs1_i),
        .id_rs2_i    (id_rs2_i),
        .id_branch_i (id_branch_i),
        .ex_wr_i     (ex_wr),
        .ex_load_i   (ex_load_i),
        .ld_stall_o  (ld_stall),
        .redirect_o  (redirect)
    );

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
            hzd_fwd_pick u_pick (
                .ex_live_i (slot_live[S_EX]),
                .src_i     (ex_src[g]),
                .mem_wr_i  (mem_wr),
                .wb_wr_i   (wb_wr),
                .sel_o     (sel[g])
            );
        end
    endgenerate

    assign fwd_a_o         = sel[0];
    assign fwd_b_o         = sel[1];
    assign stall_o         = ld_stall;
    assign bubble_o        = ld_stall;
    assign redirect_wait_o = redirect;

    // R5: the interlock never holds decode two cycles in a row
    p_stall_once_r5: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

    // R6: any forward implies a live instruction in execute
    p_fwd_live_r6: assert property (@(posedge clk) disable iff (rst)
        ((fwd_a_o != 2'b00) || (fwd_b_o != 2'b00)) |-> slot_live[S_EX]);

    // R9: first cycle after reset is quiet
    p_first_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stall_o && fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

    generate
        if (BR_BUBBLES > 1) begin : g_win_chk
            // R7: a branch window lasts beyond its first cycle
            p_window_holds_r7: assert property (@(posedge clk) disable iff (rst)
                $rose(redirect_wait_o) |=> redirect_wait_o);
        end
    endgenerate

endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid, id_branch, ex_wen, ex_load, mem_wen, wb_wen;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic [1:0] fwd_a, fwd_b;
    logic       stall, bubble, redir;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hazard_ctl u0 (
        .clk(clk), .rst(rst),
        .id_valid_i(id_valid), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_branch_i(id_branch),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_wen_i(ex_wen), .ex_load_i(ex_load),
        .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble),
        .redirect_wait_o(redir)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [4:0]  i1, i2, e1, e2, erd;
        logic        ewe, eld;
        logic [4:0]  mrd;
        logic        mwe;
        logic [4:0]  wrd;
        logic        wwe;
        logic [1:0]  fa, fb;
        logic        stl;
    } vec_t;

    localparam int NV = 15;
    // tag, id1, id2, ex1, ex2, exrd, exwe, exld, memrd, memwe, wbrd, wbwe, fa, fb, stall
    localparam vec_t VT [NV] = '{
        '{"R1",  0,  0,  5,  0, 0, 0, 0,  5, 1,  0, 0, 2'd1, 2'd0, 0},
        '{"R1",  0,  0,  0,  7, 0, 0, 0,  7, 1,  0, 0, 2'd0, 2'd1, 0},
        '{"R2",  0,  0,  9,  0, 0, 0, 0,  0, 0,  9, 1, 2'd2, 2'd0, 0},
        '{"R2",  0,  0,  3,  3, 0, 0, 0,  0, 0,  3, 1, 2'd2, 2'd2, 0},
        '{"R3",  0,  0,  4,  0, 0, 0, 0,  4, 1,  4, 1, 2'd1, 2'd0, 0},
        '{"R3",  0,  0,  4,  6, 0, 0, 0,  6, 1,  4, 1, 2'd2, 2'd1, 0},
        '{"R4",  0,  0,  0,  0, 0, 0, 0,  0, 1,  0, 1, 2'd0, 2'd0, 0},
        '{"R4",  0,  0,  0,  0, 0, 1, 1,  0, 0,  0, 0, 2'd0, 2'd0, 0},
        '{"R5",  8,  0,  0,  0, 8, 1, 1,  0, 0,  0, 0, 2'd0, 2'd0, 1},
        '{"R5",  0,  8,  0,  0, 8, 1, 1,  0, 0,  0, 0, 2'd0, 2'd0, 1},
        '{"R10", 8,  0,  0,  0, 8, 1, 0,  0, 0,  0, 0, 2'd0, 2'd0, 0},
        '{"R10",12, 12,  1,  2, 0, 0, 0,  0, 0, 12, 1, 2'd0, 2'd0, 0},
        '{"R1",  0,  0,  5,  0, 0, 0, 0,  5, 0,  0, 0, 2'd0, 2'd0, 0},
        '{"R5",  9,  0,  0,  0, 8, 1, 1,  0, 0,  0, 0, 2'd0, 2'd0, 0},
        '{"R3",  0,  0, 11, 11, 0, 0, 0, 11, 1, 11, 1, 2'd1, 2'd1, 0}
    };

    task automatic chk(string req, string what, logic [3:0] got, logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic quiet();
        id_valid = 1'b1; id_branch = 1'b0; id_rs1 = 0; id_rs2 = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wen = 0; ex_load = 0;
        mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
    endtask

    task automatic refill();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            quiet();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        quiet();
        // R9: hazards shown during reset must not act in the first cycle after it
        ex_rs1 = 5; mem_rd = 5; mem_wen = 1;
        id_rs1 = 8; ex_rd = 8; ex_wen = 1; ex_load = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9", "stall", {3'b0, stall}, 4'h0);
        chk("R9", "fwd_a", {2'b0, fwd_a}, 4'h0);
        chk("R9", "redirect", {3'b0, redir}, 4'h0);

        // table of single-cycle patterns, pipeline full before each
        for (int v = 0; v < NV; v++) begin
            refill();
            @(negedge clk);
            quiet();
            id_rs1 = VT[v].i1; id_rs2 = VT[v].i2;
            ex_rs1 = VT[v].e1; ex_rs2 = VT[v].e2; ex_rd = VT[v].erd;
            ex_wen = VT[v].ewe; ex_load = VT[v].eld;
            mem_rd = VT[v].mrd; mem_wen = VT[v].mwe;
            wb_rd = VT[v].wrd; wb_wen = VT[v].wwe;
            #1;
            chk($sformatf("%s", VT[v].tag), $sformatf("vec%0d fwd_a", v), {2'b0, fwd_a}, {2'b0, VT[v].fa});
            chk($sformatf("%s", VT[v].tag), $sformatf("vec%0d fwd_b", v), {2'b0, fwd_b}, {2'b0, VT[v].fb});
            chk($sformatf("%s", VT[v].tag), $sformatf("vec%0d stall", v), {3'b0, stall}, {3'b0, VT[v].stl});
            chk($sformatf("%s", VT[v].tag), $sformatf("vec%0d bubble", v), {3'b0, bubble}, {3'b0, VT[v].stl});
        end

        // R5: empty decode slot never stalls
        refill();
        @(negedge clk);
        quiet();
        id_valid = 0; id_rs1 = 8; ex_rd = 8; ex_wen = 1; ex_load = 1;
        #1;
        chk("R5", "stall empty decode", {3'b0, stall}, 4'h0);

        // R5 and R6: load-use interlock, then forward past the bubble
        refill();
        @(negedge clk);
        quiet();
        id_rs1 = 8; ex_rd = 8; ex_wen = 1; ex_load = 1;
        #1;
        chk("R5", "stall on load-use", {3'b0, stall}, 4'h1);
        @(negedge clk);
        id_rs1 = 8; ex_rs1 = 8; mem_rd = 8; mem_wen = 1;
        #1;
        chk("R5", "stall second cycle", {3'b0, stall}, 4'h0);
        chk("R6", "fwd_a with empty execute", {2'b0, fwd_a}, 4'h0);
        @(negedge clk);
        quiet();
        ex_rs1 = 8; mem_rd = 8; mem_wen = 1; wb_rd = 8; wb_wen = 1;
        #1;
        chk("R6", "fwd_a past bubble", {2'b0, fwd_a}, 4'h2);

        // R7: plain branch window
        refill();
        @(negedge clk);
        quiet();
        id_branch = 1; id_rs1 = 3;
        #1;
        chk("R7", "redirect cycle0", {3'b0, redir}, 4'h1);
        @(negedge clk);
        quiet();
        id_valid = 0;
        #1;
        chk("R7", "redirect cycle1", {3'b0, redir}, 4'h1);
        @(negedge clk);
        #1;
        chk("R7", "redirect cycle2", {3'b0, redir}, 4'h0);

        // R8: branch behind a load-use stall
        refill();
        @(negedge clk);
        quiet();
        id_branch = 1; id_rs1 = 8; ex_rd = 8; ex_wen = 1; ex_load = 1;
        #1;
        chk("R8", "stall with branch", {3'b0, stall}, 4'h1);
        chk("R8", "redirect during stall", {3'b0, redir}, 4'h0);
        @(negedge clk);
        #1;
        chk("R8", "stall after", {3'b0, stall}, 4'h0);
        chk("R8", "redirect cycle0", {3'b0, redir}, 4'h1);
        @(negedge clk);
        quiet();
        id_valid = 0;
        #1;
        chk("R8", "redirect cycle1", {3'b0, redir}, 4'h1);
        @(negedge clk);
        #1;
        chk("R8", "redirect cycle2", {3'b0, redir}, 4'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule